// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This peripheral guards a system against software that stops making progress. A counter advances by one on every cycle where a synchronous slow-tick enable is high, typically a 32.768 kHz strobe in the bus clock domain. Two programmable limits sit on that count. The lower limit produces a one-cycle warning interrupt so software can still react. The higher limit raises a reset request that stays high until the block itself is reset. Software keeps the timer quiet by writing a restart command before the warning limit is reached. It switches the timer on and off through a control register. It can read the running count at any time.

The control is a small state machine with four named states. `WS_IDLE` means the timer is disabled and the counter is frozen. `WS_COUNT` means the timer is running and no warning has been raised. `WS_BARKED` means the warning has fired and the timer is still running. `WS_BITTEN` means the reset request has been issued and everything is frozen.

The transitions are:
- IDLE to COUNT on enable.
- COUNT or BARKED to IDLE on disable.
- COUNT to BARKED when the warning limit is met, which also produces the interrupt pulse.
- BARKED back to COUNT when the count falls below the warning limit again, normally after a restart.
- COUNT or BARKED to BITTEN when the reset limit is met. BITTEN is left only through the block reset.

Top module: `wdt_bark_bite`

## Requirements
- R1: After `rst_n` is low, the count, the enable bit and both limits are zero, and `bark_irq` and `bite_req` are low.
- R2: Register byte offsets are as follows.
  - 0x04: restart (reads 0).
  - 0x08: enable, bit 0.
  - 0x0C: status. Bit 0 is the enable bit, bits [CNT_W:1] hold the count, and the bits above read 0.
  - 0x10: warning limit.
  - 0x14: reset limit.
  
  Both limits read back what was written. Any other offset reads 0 and ignores writes.
- R3: While enabled and running, the count rises by exactly one on each cycle where `tick_en` is high. While disabled, ticks leave the count unchanged.
- R4: A write of bit 0 = 1 to the restart register clears the count. It also wins over a tick in the same cycle.
- R5: When the count is at or above a nonzero warning limit while enabled, `bark_irq` pulses high for exactly one cycle. It pulses again only after the count has dropped below the limit and risen back to it.
- R6: When the count is at or above a nonzero reset limit while enabled, `bite_req` goes high and stays high until `rst_n`. From then on, neither ticks nor restart writes change the count.
- R7: A limit of zero never triggers its event.
- R8: The count saturates at its all-ones value instead of wrapping.
- R9: Clearing the enable bit freezes the count and suppresses both events. Setting it again resumes counting from the held value.
- R10: The suspend order (restart, then disable) leaves the count at zero with no events. The resume order (enable, then restart) restarts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Synchronous slow-tick strobe, one cycle per tick |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| bark_irq | output | 1 | One-cycle warning interrupt pulse |
| bite_req | output | 1 | Sticky reset request |

## Verification
The bench builds the block with a 6-bit counter, so the all-ones value of 63 can be reached in a few dozen ticks and saturation is observable directly. With limits this small, a sweep over warning limits 1 through 5 is practical. Each reset limit sits three ticks above its warning limit. Every tick of each sweep is followed by a status read, and the expected count, warning pulse count and reset-request level are computed as closed-form functions of the tick number.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_COUNT  = 2'd1,
        WS_BARKED = 2'd2,
        WS_BITTEN = 2'd3
    } wdt_state_e;

    localparam logic [7:0] OFS_PET    = 8'h04;
    localparam logic [7:0] OFS_ENABLE = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h0C;
    localparam logic [7:0] OFS_BARK   = 8'h10;
    localparam logic [7:0] OFS_BITE   = 8'h14;

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic              pet_o,
    output logic [CNT_W-1:0]  bark_thr_o,
    output logic [CNT_W-1:0]  bite_thr_o
);

    logic wr_en, wr_bark, wr_bite;

    assign wr_en   = bus_sel && bus_wr && (bus_addr == OFS_ENABLE[ADDR_W-1:0]);
    assign wr_bark = bus_sel && bus_wr && (bus_addr == OFS_BARK[ADDR_W-1:0]);
    assign wr_bite = bus_sel && bus_wr && (bus_addr == OFS_BITE[ADDR_W-1:0]);
    assign pet_o   = bus_sel && bus_wr && (bus_addr == OFS_PET[ADDR_W-1:0])
                     && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o       <= 1'b0;
            bark_thr_o <= '0;
            bite_thr_o <= '0;
        end else begin
            if (wr_en)   en_o       <= bus_wdata[0];
            if (wr_bark) bark_thr_o <= bus_wdata[CNT_W-1:0];
            if (wr_bite) bite_thr_o <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (bus_addr == OFS_ENABLE[ADDR_W-1:0]) begin
            rdata_o[0] = en_o;
        end else if (bus_addr == OFS_STATUS[ADDR_W-1:0]) begin
            rdata_o[0]       = en_o;
            rdata_o[CNT_W:1] = count_i;
        end else if (bus_addr == OFS_BARK[ADDR_W-1:0]) begin
            rdata_o[CNT_W-1:0] = bark_thr_o;
        end else if (bus_addr == OFS_BITE[ADDR_W-1:0]) begin
            rdata_o[CNT_W-1:0] = bite_thr_o;
        end
    end

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (en_o == $past(en_o)))                        // R2
        else $error("enable bit changed without a write");

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pet_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (pet_i) begin
            count_o <= '0;
        end else if (run_i && tick_i && (count_o != CNT_MAX)) begin
            count_o <= count_o + 1'b1;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |->
            ((count_o == $past(count_o) + 1'b1) || (count_o == '0))) // R3
        else $error("count moved by more than one");

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count_o) == CNT_MAX && !$past(pet_i)) |-> (count_o == CNT_MAX)) // R8
        else $error("count wrapped");

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] bark_thr_i,
    input  logic [CNT_W-1:0] bite_thr_i,
    output wdt_state_e       state_o,
    output logic             bark_irq_o,
    output logic             bite_req_o
);

    wdt_state_e state_q, state_d;
    logic bark_hit, bite_hit;

    assign bark_hit = (bark_thr_i != '0) && (count_i >= bark_thr_i);
    assign bite_hit = (bite_thr_i != '0) && (count_i >= bite_thr_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:   if (en_i) state_d = WS_COUNT;
            WS_COUNT: begin
                if (!en_i)         state_d = WS_IDLE;
                else if (bite_hit) state_d = WS_BITTEN;
                else if (bark_hit) state_d = WS_BARKED;
            end
            WS_BARKED: begin
                if (!en_i)          state_d = WS_IDLE;
                else if (bite_hit)  state_d = WS_BITTEN;
                else if (!bark_hit) state_d = WS_COUNT;
            end
            WS_BITTEN: state_d = WS_BITTEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bark_irq_o <= 1'b0;
            bite_req_o <= 1'b0;
        end else begin
            bark_irq_o <= (state_q == WS_COUNT) && en_i && bark_hit;
            bite_req_o <= (state_d == WS_BITTEN);
        end
    end

    assign state_o = state_q;

    AST_BARK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bark_irq_o |=> !bark_irq_o)                              // R5
        else $error("bark held for more than one cycle");

    AST_BITE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bite_req_o |=> bite_req_o)                               // R6
        else $error("bite request dropped");

    AST_ZERO_BARK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bark_thr_i) == '0) |-> !bark_irq_o)               // R7
        else $error("bark with zero limit");

endmodule

// File: rtl/wdt_bark_bite.sv
module wdt_bark_bite
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bark_irq,
    output logic              bite_req
);

    logic             en;
    logic             pet_wr;
    logic             pet_ok;
    logic             run;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] bark_thr;
    logic [CNT_W-1:0] bite_thr;
    wdt_state_e       state;

    assign run    = en && ((state == WS_COUNT) || (state == WS_BARKED));
    assign pet_ok = pet_wr && (state != WS_BITTEN);

    wdt_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count_i    (count),
        .rdata_o    (bus_rdata),
        .en_o       (en),
        .pet_o      (pet_wr),
        .bark_thr_o (bark_thr),
        .bite_thr_o (bite_thr)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .pet_i   (pet_ok),
        .run_i   (run),
        .tick_i  (tick_en),
        .count_o (count)
    );

    wdt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .count_i    (count),
        .bark_thr_i (bark_thr),
        .bite_thr_i (bite_thr),
        .state_o    (state),
        .bark_irq_o (bark_irq),
        .bite_req_o (bite_req)
    );

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pet_wr) |=> $stable(count))                     // R9
        else $error("count moved while disabled");

    AST_PET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pet_wr && !bite_req) |=> (count == '0))                 // R4
        else $error("restart did not clear count");

    AST_NO_BARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !bark_irq)                                // R9
        else $error("bark while disabled");

endmodule

// File: tb/wdt_bark_bite_bench.sv
module wdt_bark_bite_bench;

    localparam int CNT_W  = 6;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bark_irq;
    logic              bite_req;

    int n_cmp = 0;
    int n_bad = 0;
    int bark_seen = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wdt_bark_bite #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wdt_bark_bite (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bark_irq(bark_irq), .bite_req(bite_req)
    );

    always @(negedge clk) begin
        if (!rst_n)        bark_seen <= 0;
        else if (bark_irq) bark_seen <= bark_seen + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr[ADDR_W-1:0]; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        bus_addr = addr[ADDR_W-1:0]; bus_sel = 1'b1;
        #1 data = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
        idle(2);
    endtask

    task automatic count_is(input string req, input int exp);
        int v;
        rd(8'h0C, v);
        chk(req, (v >> 1) & CMAX, exp);
    endtask

    task automatic enable_on();
        wr(8'h08, 1);
        idle(2);
    endtask

    initial begin
        int v;
        do_reset();
        // R1: reset state
        count_is("R1 count", 0);
        rd(8'h08, v); chk("R1 enable", v, 0);
        rd(8'h10, v); chk("R1 bark limit", v, 0);
        rd(8'h14, v); chk("R1 bite limit", v, 0);
        chk("R1 bark_irq", bark_irq, 0);
        chk("R1 bite_req", bite_req, 0);

        // R2: register map and read formats
        wr(8'h10, 5); wr(8'h14, 9);
        rd(8'h10, v); chk("R2 bark readback", v, 5);
        rd(8'h14, v); chk("R2 bite readback", v, 9);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 unmapped read", v, 0);
        rd(8'h18, v); chk("R2 unmapped read 0x18", v, 0);
        // R3: ticks while disabled have no effect
        ticks(4);
        count_is("R3 disabled ticks", 0);
        enable_on();
        rd(8'h08, v); chk("R2 enable readback", v, 1);
        ticks(3);
        rd(8'h0C, v);
        chk("R2 status enable bit", v & 1, 1);
        chk("R2 status count field", (v >> 1) & CMAX, 3);
        chk("R2 status upper zero", v >>> (CNT_W + 1), 0);
        rd(8'h04, v); chk("R2 restart reads zero", v, 0);

        // R4: restart, bit0=0 ignored, restart beats tick
        wr(8'h04, 2);
        count_is("R4 restart bit0 clear ignored", 3);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = 1; tick_en = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
        count_is("R4 restart with tick", 0);

        // R9: disable freezes, re-enable resumes
        ticks(4);
        wr(8'h08, 0);
        ticks(10);
        count_is("R9 frozen when disabled", 4);
        chk("R9 no bark when disabled", bark_seen, 0);
        enable_on();
        ticks(1);
        count_is("R9 resumes from held value", 5);
        chk("R5 bark at limit", bark_seen, 1);
        // R5: rearm after restart
        wr(8'h04, 1);
        idle(2);
        ticks(5);
        chk("R5 second bark after restart", bark_seen, 2);
        ticks(1);
        chk("R5 no repeat while above limit", bark_seen, 2);
        // R5: lowering the limit below the count triggers
        wr(8'h04, 1); idle(2); ticks(2);
        wr(8'h10, 1); idle(2);
        chk("R5 lowered limit fires", bark_seen, 3);

        // R6: near-exhaustive sweep of small limits
        for (int b = 1; b <= 5; b++) begin
            do_reset();
            wr(8'h10, b); wr(8'h14, b + 3);
            enable_on();
            for (int t = 1; t <= b + 5; t++) begin
                ticks(1);
                count_is("R6 sweep count", (t < b + 3) ? t : b + 3);
                chk("R5 sweep bark", bark_seen, (t >= b) ? 1 : 0);
                chk("R6 sweep bite", bite_req, (t >= b + 3) ? 1 : 0);
            end
            wr(8'h04, 1); idle(2);
            count_is("R6 restart ignored after bite", b + 3);
            chk("R6 bite sticky", bite_req, 1);
        end

        // R7, R8: zero limits, saturation
        do_reset();
        enable_on();
        ticks(CMAX + 6);
        count_is("R8 saturate", CMAX);
        chk("R7 zero bark limit", bark_seen, 0);
        chk("R7 zero bite limit", bite_req, 0);

        // R10: suspend then resume ordering
        do_reset();
        wr(8'h10, 3); wr(8'h14, 6);
        enable_on();
        ticks(2);
        wr(8'h04, 1); wr(8'h08, 0);
        ticks(8);
        count_is("R10 suspended count", 0);
        chk("R10 no bark in suspend", bark_seen, 0);
        chk("R10 no bite in suspend", bite_req, 0);
        wr(8'h08, 1); wr(8'h04, 1); idle(2);
        ticks(2);
        count_is("R10 resumed count", 2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule